// File: doc/BRIEF.md
# Integer ALU with Compare-and-Set

A purely combinational 32-bit integer arithmetic/logic unit for a small load/store processor core. Each cycle the core presents two operands and a 5-bit operation code, and the unit answers with a 32-bit result and a signed-overflow flag in the same cycle. The second operand is either a register value or an immediate that the decode stage has already extended. Register and immediate forms of an instruction therefore share one operation code.

The unit adds and subtracts, with signed and unsigned flavours that differ only in the overflow flag. It also performs bitwise AND, OR, XOR and one's complement, logical and arithmetic shifts by a 5-bit amount, and places a 16-bit constant in the upper half of the word. Six compare-and-set relations (equal, not equal, signed and unsigned less than, signed and unsigned greater than) produce the word 0 or 1. Multiply, divide and floating point are not provided. Overflow is reported as a flag, and any exception it raises is the core's concern.

Top module: `rasc_alu`

## Requirements
- R1: Codes 0 (add), 1 (add unsigned), 2 (subtract) and 3 (subtract unsigned) give `opa+opb` or `opa-opb` modulo 2^32. The signed and unsigned codes give identical result bits.
- R2: `ovf` is 1 only for code 0 when the two's-complement sum of the operands leaves the 32-bit signed range, or for code 2 when their difference does. For every other code `ovf` is 0.
- R3: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of `opa` and `opb`.
- R4: Code 7 gives `~opa`, and `opb` has no effect on the result.
- R5: Codes 8 (left logical), 9 (right logical) and 10 (right arithmetic, sign bit replicated) shift `opa` by `opb[4:0]`. Bits `opb[31:5]` have no effect.
- R6: Code 11 gives `{opb[15:0], 16'h0000}`, so the low 16 bits of the result are zero.
- R7: Codes 12 (equal), 13 (not equal), 14 (signed less than), 15 (signed greater than), 16 (unsigned less than) and 17 (unsigned greater than) give 32'd1 when `opa` relation `opb` holds and 32'd0 otherwise. The signed relations compare two's-complement values.
- R8: Codes 18 to 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opa | input | 32 | First operand (register value) |
| opb | input | 32 | Second operand (register value or pre-extended immediate) |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of codes 0 and 2 |

## Verification
The in-design checks assume that the three inputs are stable, known values whenever they are evaluated. They do not look at intermediate values while a new operand is still propagating. The bench changes inputs only just after the rising clock edge and compares results at the falling edge, so every comparison sees settled logic. The stimulus walks all 32 operation codes with sign-boundary operands, shift amounts whose upper bits are set, and then pseudo-random operand pairs.

// File: rtl/rasc_alu_pkg.sv
package rasc_alu_pkg;

    localparam int XLEN  = 32;
    localparam int SHAMT = $clog2(XLEN);
    localparam int HALF  = XLEN / 2;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOT  = 5'd7,
        OP_SLL  = 5'd8,
        OP_SRL  = 5'd9,
        OP_SRA  = 5'd10,
        OP_LHI  = 5'd11,
        OP_SEQ  = 5'd12,
        OP_SNE  = 5'd13,
        OP_SLT  = 5'd14,
        OP_SGT  = 5'd15,
        OP_SLTU = 5'd16,
        OP_SGTU = 5'd17
    } op_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            ovf;
    } sum_t;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } rel_t;

    function automatic logic is_subtract(op_e op);
        return (op == OP_SUB) || (op == OP_SUBU);
    endfunction

    function automatic logic is_compare(op_e op);
        return (op >= OP_SEQ) && (op <= OP_SGTU);
    endfunction

    function automatic logic is_signed_arith(op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/rasc_addsub.sv
module rasc_addsub
    import rasc_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   raw;

    always_comb begin
        b_eff = sub ? ~b : b;
        raw   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = raw[W-1:0];
        // signed overflow: like-signed effective operands, result sign differs
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/rasc_shifter.sv
module rasc_shifter
    import rasc_alu_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          right,
    input  logic          arith,
    output logic [W-1:0]  out
);
    logic [W-1:0] val_rev;
    logic [W-1:0] stage [SW+1];
    logic [W-1:0] stage_rev;
    logic         fill;

    // bit reversal lets one right-shifter serve left shifts too
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign val_rev[i]   = val[W-1-i];
        assign stage_rev[i] = stage[SW][W-1-i];
    end

    assign fill     = right & arith & val[W-1];
    assign stage[0] = right ? val : val_rev;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
    end

    assign out = right ? stage[SW] : stage_rev;
endmodule

// File: rtl/rasc_compare.sv
module rasc_compare
    import rasc_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_t         rel
);
    logic [W:0] diff_s;
    logic [W:0] diff_u;

    always_comb begin
        diff_s   = {a[W-1], a} - {b[W-1], b};
        diff_u   = {1'b0, a} - {1'b0, b};
        rel.eq   = (a == b);
        rel.lt_s = diff_s[W];
        rel.lt_u = diff_u[W];
    end
endmodule

// File: rtl/rasc_alu.sv
module rasc_alu
    import rasc_alu_pkg::*;
(
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result,
    output logic            ovf
);
    op_e             op;
    sum_t            as_out;
    rel_t            rel;
    logic [XLEN-1:0] sh_out;
    logic            hit;

    assign op = op_e'(op_sel);

    rasc_addsub #(.W(XLEN)) u_addsub (
        .a   (opa),
        .b   (opb),
        .sub (is_subtract(op)),
        .sum (as_out.value),
        .ovf (as_out.ovf)
    );

    rasc_shifter #(.W(XLEN)) u_shift (
        .val   (opa),
        .amt   (opb[SHAMT-1:0]),
        .right (op != OP_SLL),
        .arith (op == OP_SRA),
        .out   (sh_out)
    );

    rasc_compare #(.W(XLEN)) u_cmp (
        .a   (opa),
        .b   (opb),
        .rel (rel)
    );

    always_comb begin
        hit = 1'b0;
        unique case (op)
            OP_SEQ:  hit = rel.eq;
            OP_SNE:  hit = !rel.eq;
            OP_SLT:  hit = rel.lt_s;
            OP_SGT:  hit = !rel.lt_s && !rel.eq;
            OP_SLTU: hit = rel.lt_u;
            OP_SGTU: hit = !rel.lt_u && !rel.eq;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        result = '0;
        ovf    = is_signed_arith(op) & as_out.ovf;
        case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = as_out.value;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_XOR:  result = opa ^ opb;
            OP_NOT:  result = ~opa;
            OP_SLL, OP_SRL, OP_SRA: result = sh_out;
            OP_LHI:  result = {opb[HALF-1:0], {HALF{1'b0}}};
            default: result = is_compare(op) ? {{(XLEN-1){1'b0}}, hit} : '0;
        endcase
    end

    // Checks on the settled outputs against the operands
    always_comb begin
        // R2
        no_overflow_chk: assert (is_signed_arith(op) || !ovf)
            else $error("overflow flag raised for a non-signed operation");
        // R7
        cmp_bool_chk: assert (!is_compare(op) || result[XLEN-1:1] == '0)
            else $error("compare result is not 0 or 1");
        // R7
        seq_match_chk: assert (op != OP_SEQ || result[0] == (opa == opb))
            else $error("equality result disagrees with operands");
        // R6
        lhi_low_chk: assert (op != OP_LHI || result[HALF-1:0] == '0)
            else $error("load-high left low half nonzero");
        // R5
        sra_sign_chk: assert (op != OP_SRA || result[XLEN-1] == opa[XLEN-1])
            else $error("arithmetic shift lost the sign");
        // R1
        addu_no_flag_chk: assert (!(op == OP_ADDU || op == OP_SUBU) || !ovf)
            else $error("unsigned arithmetic flagged overflow");
        // R8
        undef_zero_chk: assert (op_sel <= 5'd17 || (result == '0 && !ovf))
            else $error("undefined code produced a nonzero result");
    end
endmodule

// File: tb/rasc_alu_test.sv
module rasc_alu_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rasc_alu uut (
        .op_sel (op_sel),
        .opa    (opa),
        .opb    (opb),
        .result (result),
        .ovf    (ovf)
    );

    function automatic string req_of(int code);
        if (code <= 3)  return "R1";
        if (code <= 6)  return "R3";
        if (code == 7)  return "R4";
        if (code <= 10) return "R5";
        if (code == 11) return "R6";
        if (code <= 17) return "R7";
        return "R8";
    endfunction

    // behavioural model written from the requirement list
    function automatic void model(input int code, input logic [31:0] a,
                                  input logic [31:0] b,
                                  output logic [31:0] r, output logic f);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint s;
        int     sh = int'(b[4:0]);
        f = 1'b0;
        r = '0;
        case (code)
            0, 1: begin
                r = a + b;
                s = sa + sb;
                if (code == 0) f = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            2, 3: begin
                r = a - b;
                s = sa - sb;
                if (code == 2) f = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4:  r = a & b;
            5:  r = a | b;
            6:  r = a ^ b;
            7:  r = ~a;
            8:  r = a << sh;
            9:  r = a >> sh;
            10: r = $unsigned($signed(a) >>> sh);
            11: r = {b[15:0], 16'h0};
            12: r = 32'(a == b);
            13: r = 32'(a != b);
            14: r = 32'(sa < sb);
            15: r = 32'(sa > sb);
            16: r = 32'(a < b);
            17: r = 32'(a > b);
            default: r = '0;
        endcase
    endfunction

    task automatic apply(input int code, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp_r;
        logic        exp_f;
        @(posedge clk);
        #1;
        op_sel = 5'(code);
        opa    = a;
        opb    = b;
        model(code, a, b, exp_r, exp_f);
        @(negedge clk);
        checks++;
        if (result !== exp_r) begin
            fails++;
            $display("FAIL %s code %0d a=%h b=%h result=%h expected=%h",
                     req_of(code), code, a, b, result, exp_r);
        end
        checks++;
        if (ovf !== exp_f) begin
            fails++;
            $display("FAIL R2 code %0d a=%h b=%h ovf=%0b expected=%0b",
                     code, a, b, ovf, exp_f);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset/idle state: code 0 with zero operands (R1)
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || ovf !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle result=%h ovf=%0b expected=0 0", result, ovf);
        end
        // R1 / R2 boundaries
        apply(0, 32'h7fff_ffff, 32'h0000_0001);
        apply(1, 32'h7fff_ffff, 32'h0000_0001);
        apply(0, 32'h8000_0000, 32'h8000_0000);
        apply(2, 32'h8000_0000, 32'h0000_0001);
        apply(3, 32'h8000_0000, 32'h0000_0001);
        apply(2, 32'h7fff_ffff, 32'hffff_ffff);
        apply(0, 32'hffff_ffff, 32'h0000_0001);
        // R3
        apply(4, 32'hf0f0_1234, 32'hff00_ff00);
        apply(5, 32'hf0f0_1234, 32'h0f00_00ff);
        apply(6, 32'haaaa_5555, 32'hffff_0000);
        // R4: two different opb values, same opa
        apply(7, 32'h1234_5678, 32'h0000_0000);
        apply(7, 32'h1234_5678, 32'hdead_beef);
        // R5: upper amount bits set must be ignored
        apply(8, 32'h0000_0001, 32'hffff_ffe4);
        apply(9, 32'h8000_0000, 32'h0000_003f);
        apply(10, 32'h8000_0000, 32'h0000_001f);
        apply(10, 32'h4000_0000, 32'h0000_0110);
        apply(8, 32'hdead_beef, 32'h0000_0020);
        // R6
        apply(11, 32'h5555_5555, 32'hffff_abcd);
        // R7 signed vs unsigned disagreement and equality
        apply(14, 32'hffff_ffff, 32'h0000_0001);
        apply(16, 32'hffff_ffff, 32'h0000_0001);
        apply(15, 32'hffff_ffff, 32'h0000_0001);
        apply(17, 32'hffff_ffff, 32'h0000_0001);
        apply(12, 32'h0000_0042, 32'h0000_0042);
        apply(13, 32'h0000_0042, 32'h0000_0042);
        apply(15, 32'h0000_0042, 32'h0000_0042);
        apply(17, 32'h0000_0042, 32'h0000_0042);
        // every code including undefined ones (R8)
        for (int c = 0; c < 32; c++) begin
            apply(c, 32'h8765_4321, 32'h0000_0013);
            apply(c, 32'h0000_0013, 32'h8765_4321);
        end
        // pseudo-random sweep
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            if (n % 5 == 0) rb = ra;
            apply(n % 32, ra, rb);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule